// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This unit owns the stack pointer and the instruction pointer of a 64-bit core and runs the stack and control-flow operations against a single-port memory of 8-byte words. Push, pop, call and return each need one memory access. A request starts that access and ends when the memory signals ready, and only then are the pointers updated. Jumps, conditional jumps, stack-pointer loads and address computations finish in the cycle they are accepted, without any memory traffic.

The stack grows toward lower addresses, and the stack pointer always addresses the item on top. A push or call stores its word just below the current top. A pop or return reads the top word. An effective-address generator adds a base, a scaled index and a sign-extended 32-bit displacement. The address-computation operation uses it to hand the address itself to a destination. A memory access whose address is not a multiple of 8 is not started, and an alignment error pulse reports the refusal.

Top module: `stkctl_seq`

## Requirements
- R1: After reset the stack pointer equals SP_RST, the instruction pointer equals IP_RST, and busy, mem_req, done, align_err, idx_err and dst_we are all low.
- R2: Push (op code 1) writes src_val to address sp-8. When the handshake completes, the stack pointer becomes sp-8 and done pulses for one cycle.
- R3: Pop (op code 2) reads the word at address sp. When the handshake completes, that word is presented on dst_val with a one-cycle dst_we, and the stack pointer becomes sp+8.
- R4: Call (op code 3) writes nxt_ip to address sp-8. On completion the stack pointer becomes sp-8 and the instruction pointer becomes tgt_val.
- R5: Return (op code 4) reads the word at address sp into the instruction pointer and raises the stack pointer by 8. No destination write occurs.
- R6: Jump (op code 5) loads tgt_val into the instruction pointer. Conditional jump (op code 6) loads tgt_val when cond_taken is 1 and nxt_ip when it is 0. Both finish with done in the cycle after acceptance and make no memory access.
- R7: Address computation (op code 7) produces base + index×2^scale_sel + sign-extended disp on dst_val with dst_we, where scale_sel 0..3 means ×1, ×2, ×4, ×8. The base is the stack pointer when base_sp is 1 and base_val otherwise. The index term is zero when idx_en is 0. No memory is accessed.
- R8: When an address computation names the stack pointer as its index (idx_en and idx_sp both 1), idx_err pulses instead of done, dst_we stays low, and both pointers keep their values.
- R9: A push, pop, call or return whose access address has a nonzero value in bits [2:0] raises align_err for one cycle, starts no memory access, and leaves both pointers unchanged. Every address presented on mem_req is a multiple of 8.
- R10: busy is high from the cycle after a memory operation is accepted until its handshake completes. During that time the memory request fields stay stable, the pointers do not change, and requests presented to the unit are ignored.
- R11: Stack-pointer load (op code 0) sets the stack pointer to src_val. It and every other operation that does not transfer control (push, pop, stack-pointer load, address computation) set the instruction pointer to nxt_ip on completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request; taken only while idle |
| req_op | input | 3 | Operation code (see requirements) |
| src_val | input | 64 | Value to push, or new stack pointer |
| tgt_val | input | 64 | Jump or call target |
| nxt_ip | input | 64 | Fall-through instruction address |
| cond_taken | input | 1 | Condition result for the conditional jump |
| base_val | input | 64 | Base register value for address computation |
| base_sp | input | 1 | Use the stack pointer as base |
| idx_val | input | 64 | Index register value |
| idx_en | input | 1 | Index term present |
| idx_sp | input | 1 | Index names the stack pointer (illegal) |
| scale_sel | input | 2 | Index scale exponent |
| disp | input | 32 | Signed displacement |
| busy | output | 1 | Memory sequence in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Memory write word |
| mem_rdata | input | 64 | Memory read word, valid with mem_rdy |
| mem_rdy | input | 1 | Memory completes the request this cycle |
| sp_o | output | 64 | Stack pointer |
| ip_o | output | 64 | Instruction pointer |
| dst_we | output | 1 | Destination write pulse |
| dst_val | output | 64 | Destination value |
| done | output | 1 | Operation completed |
| align_err | output | 1 | Operation refused for misalignment |
| idx_err | output | 1 | Address computation refused for a stack-pointer index |

## Verification
The completion of a memory handshake and a newly presented request can occur in the same cycle. The bench provokes this by holding a jump request high for the whole of a call that waits several cycles for memory, including the completing cycle. The result is judged by whether the instruction pointer ends at the call target rather than the jump target, and whether any further completion pulse follows in the next cycle. A second pairing is the stack-pointer load followed directly by a push or pop. A misaligned pointer must then be refused with the pointers intact and without any memory access, which the bench counts at the memory model.

// File: rtl/stkctl_pkg.sv
package stkctl_pkg;
  typedef enum logic [2:0] {
    OP_SETSP = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_JMP   = 3'd5,
    OP_JCC   = 3'd6,
    OP_LEA   = 3'd7
  } stk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEM  = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stkctl_agen.sv
module stkctl_agen #(
  parameter int DW      = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic [DW-1:0]      base,
  input  logic [DW-1:0]      idx,
  input  logic               idx_en,
  input  logic [SCALE_W-1:0] scale_sel,
  input  logic [DISP_W-1:0]  disp,
  output logic [DW-1:0]      ea
);
  logic [DW-1:0] disp_ext;
  logic [DW-1:0] idx_term;

  generate
    if (DISP_W < DW) begin : g_sext
      assign disp_ext = {{(DW-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[DW-1:0];
    end
  endgenerate

  always_comb begin
    idx_term = idx_en ? (idx << scale_sel) : '0;
    ea       = base + idx_term + disp_ext;
  end
endmodule

// File: rtl/stkctl_ptrs.sv
module stkctl_ptrs #(
  parameter int            DW     = 64,
  parameter logic [DW-1:0] SP_RST = '0,
  parameter logic [DW-1:0] IP_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_we,
  input  logic [DW-1:0] sp_nxt,
  input  logic          ip_we,
  input  logic [DW-1:0] ip_nxt,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] ip_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_RST;
    end else if (sp_we) begin
      sp_q <= sp_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= IP_RST;
    end else if (ip_we) begin
      ip_q <= ip_nxt;
    end
  end
endmodule

// File: rtl/stkctl_fsm.sv
module stkctl_fsm
  import stkctl_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [DW-1:0] src_val,
  input  logic [DW-1:0] tgt_val,
  input  logic [DW-1:0] nxt_ip,
  input  logic          cond_taken,
  input  logic [DW-1:0] ea,
  input  logic          idx_fault,
  input  logic [DW-1:0] sp_q,
  input  logic          mem_rdy,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          sp_we,
  output logic [DW-1:0] sp_nxt,
  output logic          ip_we,
  output logic [DW-1:0] ip_nxt,
  output logic          dst_we,
  output logic [DW-1:0] dst_val,
  output logic          done,
  output logic          align_err,
  output logic          idx_err
);
  localparam int            WORD_BYTES = DW / 8;
  localparam int            ALIGN_W    = $clog2(WORD_BYTES);
  localparam logic [DW-1:0] STEP       = DW'(WORD_BYTES);

  stk_state_e    st_q, st_d;
  stk_op_e       op_q, op_in;
  logic [DW-1:0] addr_q, wdata_q, tgt_q, nip_q;
  logic          latch_en;
  logic          is_mem_op, is_write_op, misalign;
  logic [DW-1:0] acc_addr;
  logic          done_d, align_d, idx_d, dst_we_d;
  logic [DW-1:0] dst_val_d;

  always_comb begin
    op_in       = stk_op_e'(req_op);
    is_mem_op   = (op_in == OP_PUSH) || (op_in == OP_POP) ||
                  (op_in == OP_CALL) || (op_in == OP_RET);
    is_write_op = (op_in == OP_PUSH) || (op_in == OP_CALL);
    acc_addr    = is_write_op ? (sp_q - STEP) : sp_q;
    misalign    = |acc_addr[ALIGN_W-1:0];
  end

  always_comb begin
    st_d      = st_q;
    latch_en  = 1'b0;
    sp_we     = 1'b0;
    sp_nxt    = sp_q;
    ip_we     = 1'b0;
    ip_nxt    = nxt_ip;
    done_d    = 1'b0;
    align_d   = 1'b0;
    idx_d     = 1'b0;
    dst_we_d  = 1'b0;
    dst_val_d = ea;
    if (st_q == ST_IDLE) begin
      if (req_valid) begin
        if (is_mem_op) begin
          if (misalign) begin
            align_d = 1'b1;
          end else begin
            st_d     = ST_MEM;
            latch_en = 1'b1;
          end
        end else begin
          case (op_in)
            OP_SETSP: begin
              sp_we  = 1'b1;
              sp_nxt = src_val;
              ip_we  = 1'b1;
              done_d = 1'b1;
            end
            OP_JMP: begin
              ip_we  = 1'b1;
              ip_nxt = tgt_val;
              done_d = 1'b1;
            end
            OP_JCC: begin
              ip_we  = 1'b1;
              ip_nxt = cond_taken ? tgt_val : nxt_ip;
              done_d = 1'b1;
            end
            default: begin
              if (idx_fault) begin
                idx_d = 1'b1;
              end else begin
                dst_we_d = 1'b1;
                ip_we    = 1'b1;
                done_d   = 1'b1;
              end
            end
          endcase
        end
      end
    end else if (mem_rdy) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      sp_we  = 1'b1;
      ip_we  = 1'b1;
      ip_nxt = nip_q;
      case (op_q)
        OP_PUSH: sp_nxt = addr_q;
        OP_CALL: begin
          sp_nxt = addr_q;
          ip_nxt = tgt_q;
        end
        OP_POP: begin
          sp_nxt    = addr_q + STEP;
          dst_we_d  = 1'b1;
          dst_val_d = mem_rdata;
        end
        default: begin
          sp_nxt = addr_q + STEP;
          ip_nxt = mem_rdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_SETSP;
      addr_q  <= '0;
      wdata_q <= '0;
      tgt_q   <= '0;
      nip_q   <= '0;
    end else if (latch_en) begin
      op_q    <= op_in;
      addr_q  <= acc_addr;
      wdata_q <= (op_in == OP_CALL) ? nxt_ip : src_val;
      tgt_q   <= tgt_val;
      nip_q   <= nxt_ip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      align_err <= 1'b0;
      idx_err   <= 1'b0;
      dst_we    <= 1'b0;
    end else begin
      done      <= done_d;
      align_err <= align_d;
      idx_err   <= idx_d;
      dst_we    <= dst_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_val <= '0;
    end else if (dst_we_d) begin
      dst_val <= dst_val_d;
    end
  end

  always_comb begin
    busy      = (st_q == ST_MEM);
    mem_req   = (st_q == ST_MEM);
    mem_we    = (op_q == OP_PUSH) || (op_q == OP_CALL);
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
  end
endmodule

// File: rtl/stkctl_seq.sv
module stkctl_seq #(
  parameter int            DW      = 64,
  parameter int            DISP_W  = 32,
  parameter int            SCALE_W = 2,
  parameter logic [DW-1:0] SP_RST  = 64'h80,
  parameter logic [DW-1:0] IP_RST  = 64'h1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [DW-1:0]      src_val,
  input  logic [DW-1:0]      tgt_val,
  input  logic [DW-1:0]      nxt_ip,
  input  logic               cond_taken,
  input  logic [DW-1:0]      base_val,
  input  logic               base_sp,
  input  logic [DW-1:0]      idx_val,
  input  logic               idx_en,
  input  logic               idx_sp,
  input  logic [SCALE_W-1:0] scale_sel,
  input  logic [DISP_W-1:0]  disp,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               mem_rdy,
  output logic [DW-1:0]      sp_o,
  output logic [DW-1:0]      ip_o,
  output logic               dst_we,
  output logic [DW-1:0]      dst_val,
  output logic               done,
  output logic               align_err,
  output logic               idx_err
);
  logic [DW-1:0] sp_q, ip_q, base_mux, ea;
  logic          sp_we, ip_we, idx_fault;
  logic [DW-1:0] sp_nxt, ip_nxt;

  assign base_mux  = base_sp ? sp_q : base_val;
  assign idx_fault = idx_en & idx_sp;

  stkctl_agen #(.DW(DW), .DISP_W(DISP_W), .SCALE_W(SCALE_W)) agen_i (
    .base(base_mux), .idx(idx_val), .idx_en(idx_en),
    .scale_sel(scale_sel), .disp(disp), .ea(ea)
  );

  stkctl_fsm #(.DW(DW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .src_val(src_val), .tgt_val(tgt_val), .nxt_ip(nxt_ip),
    .cond_taken(cond_taken), .ea(ea), .idx_fault(idx_fault), .sp_q(sp_q),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_we(sp_we), .sp_nxt(sp_nxt), .ip_we(ip_we), .ip_nxt(ip_nxt),
    .dst_we(dst_we), .dst_val(dst_val), .done(done),
    .align_err(align_err), .idx_err(idx_err)
  );

  stkctl_ptrs #(.DW(DW), .SP_RST(SP_RST), .IP_RST(IP_RST)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .sp_we(sp_we), .sp_nxt(sp_nxt),
    .ip_we(ip_we), .ip_nxt(ip_nxt), .sp_q(sp_q), .ip_q(ip_q)
  );

  assign sp_o = sp_q;
  assign ip_o = ip_q;
endmodule

// File: rtl/stkctl_chk.sv
module stkctl_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_rdy,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] sp_o,
  input logic [DW-1:0] ip_o,
  input logic          dst_we,
  input logic          done,
  input logic          align_err,
  input logic          idx_err
);
  localparam int            ALIGN_W = $clog2(DW / 8);
  localparam logic [DW-1:0] STEP    = DW'(DW / 8);

  AST_ACCESS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ALIGN_W-1:0] == '0)); // R9
  AST_MISALIGN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (sp_o == $past(sp_o)) && (ip_o == $past(ip_o))); // R9
  AST_WRITE_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == sp_o - STEP)); // R2
  AST_READ_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == sp_o)); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_PTRS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sp_o) && $stable(ip_o)); // R10
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sp_o == $past(sp_o) + STEP) || (sp_o == $past(sp_o) - STEP)); // R2
  AST_OUTCOME_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, align_err, idx_err})); // R8
  AST_IDX_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> !dst_we && $stable(ip_o) && $stable(sp_o)); // R8
endmodule

bind stkctl_seq stkctl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_rdy(mem_rdy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .sp_o(sp_o), .ip_o(ip_o), .dst_we(dst_we), .done(done),
  .align_err(align_err), .idx_err(idx_err)
);

// File: tb/stkctl_seq_tb_top.sv
module stkctl_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [63:0] src_val = '0, tgt_val = '0, nxt_ip = '0, base_val = '0, idx_val = '0;
  logic        cond_taken = 1'b0, base_sp = 1'b0, idx_en = 1'b0, idx_sp = 1'b0;
  logic [1:0]  scale_sel = '0;
  logic [31:0] disp = '0;
  logic        busy, mem_req, mem_we, dst_we, done, align_err, idx_err;
  logic [63:0] mem_addr, mem_wdata, mem_rdata, sp_o, ip_o, dst_val;
  logic        mem_rdy = 1'b0;

  logic [63:0] mem [16];
  int lat = 0, wcnt = 0, nacc = 0;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  bit o_done, o_aerr, o_ierr, o_dwe, b_first;
  logic [63:0] o_dval;

  always #2 clk = ~clk;

  stkctl_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .src_val(src_val), .tgt_val(tgt_val), .nxt_ip(nxt_ip), .cond_taken(cond_taken),
    .base_val(base_val), .base_sp(base_sp), .idx_val(idx_val), .idx_en(idx_en),
    .idx_sp(idx_sp), .scale_sel(scale_sel), .disp(disp), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .sp_o(sp_o), .ip_o(ip_o),
    .dst_we(dst_we), .dst_val(dst_val), .done(done), .align_err(align_err),
    .idx_err(idx_err)
  );

  assign mem_rdata = mem[mem_addr[6:3]];

  always @(posedge clk) begin
    if (mem_req && mem_rdy) begin
      nacc <= nacc + 1;
      if (mem_we) mem[mem_addr[6:3]] <= mem_wdata;
    end
  end

  always @(negedge clk) begin
    if (!mem_req) begin
      wcnt = 0;
      mem_rdy = 1'b0;
    end else begin
      mem_rdy = (wcnt >= lat);
      wcnt++;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [63:0] src, logic [63:0] tgt,
                       logic [63:0] nip, logic cnd);
    @(negedge clk);
    req_op = op; src_val = src; tgt_val = tgt; nxt_ip = nip; cond_taken = cnd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    b_first = busy;
    for (int i = 0; i < 40; i++) begin
      if (done || align_err || idx_err) break;
      @(negedge clk);
    end
    o_done = done; o_aerr = align_err; o_ierr = idx_err;
    o_dwe = dst_we; o_dval = dst_val;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [63:0] sp_e, ip_e, exp_ea, bsel;
    logic [63:0] vals [4];
    logic [31:0] dlist [4];
    int acc0;
    vals  = '{64'hA1A1_0000_0000_0001, 64'hB2B2_0000_0000_0002,
              64'hC3C3_0000_0000_0003, 64'hD4D4_0000_0000_0004};
    dlist = '{32'h0, 32'h5, 32'hFFFF_FFF0, 32'h7FFF_FFFF};
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sp", sp_o, 64'h80);
    check("R1 ip", ip_o, 64'h1000);
    check("R1 quiet", {59'd0, busy, mem_req, done, align_err, dst_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {62'd0, busy, idx_err}, 64'd0);

    // R2 push sweep over memory latency, R10 busy, R11 ip
    sp_e = 64'h80;
    for (int k = 0; k < 4; k++) begin
      lat = k;
      issue(3'd1, vals[k], 64'h0, 64'h2000 + 64'(k), 1'b0);
      sp_e = sp_e - 8;
      check("R2 done", {63'd0, o_done}, 64'd1);
      check("R2 sp", sp_o, sp_e);
      check("R10 busy after accept", {63'd0, b_first}, 64'd1);
      check("R11 ip after push", ip_o, 64'h2000 + 64'(k));
      @(negedge clk);
      check("R2 memory word", mem[sp_e[6:3]], vals[k]);
    end

    // R3 pop in reverse order
    for (int k = 3; k >= 0; k--) begin
      lat = 3 - k;
      issue(3'd2, 64'h0, 64'h0, 64'h3000, 1'b0);
      check("R3 dst_we", {63'd0, o_dwe}, 64'd1);
      check("R3 dst_val", o_dval, vals[k]);
      sp_e = sp_e + 8;
      check("R3 sp", sp_o, sp_e);
    end

    // R4 call
    lat = 1;
    issue(3'd3, 64'h0, 64'h5000, 64'h1010, 1'b0);
    check("R4 ip", ip_o, 64'h5000);
    check("R4 sp", sp_o, 64'h78);
    @(negedge clk);
    check("R4 return address stored", mem[4'hF], 64'h1010);

    // R5 return
    issue(3'd4, 64'h0, 64'h0, 64'h9999, 1'b0);
    check("R5 ip", ip_o, 64'h1010);
    check("R5 sp", sp_o, 64'h80);
    check("R5 no dst write", {63'd0, o_dwe}, 64'd0);

    // R6 jumps
    acc0 = nacc;
    issue(3'd5, 64'h0, 64'h6000, 64'h1111, 1'b0);
    check("R6 jmp ip", ip_o, 64'h6000);
    check("R6 jmp immediate done", {62'd0, b_first, o_done}, 64'd1);
    issue(3'd6, 64'h0, 64'h7000, 64'h6004, 1'b1);
    check("R6 jcc taken", ip_o, 64'h7000);
    issue(3'd6, 64'h0, 64'h8000, 64'h7004, 1'b0);
    check("R6 jcc not taken", ip_o, 64'h7004);
    check("R6 no memory access", 64'(nacc - acc0), 64'd0);

    // R11 stack-pointer load to a misaligned value, R9 refusal
    issue(3'd0, 64'h44, 64'h0, 64'h7008, 1'b0);
    check("R11 sp load", sp_o, 64'h44);
    check("R11 ip after load", ip_o, 64'h7008);
    acc0 = nacc;
    issue(3'd1, 64'hFF, 64'h0, 64'hAAAA, 1'b0);
    check("R9 push align_err", {62'd0, o_aerr, o_done}, 64'd2);
    check("R9 push sp kept", sp_o, 64'h44);
    check("R9 push ip kept", ip_o, 64'h7008);
    issue(3'd4, 64'h0, 64'h0, 64'hAAAA, 1'b0);
    check("R9 ret align_err", {63'd0, o_aerr}, 64'd1);
    check("R9 ret ip kept", ip_o, 64'h7008);
    check("R9 no memory access", 64'(nacc - acc0), 64'd0);
    issue(3'd0, 64'h80, 64'h0, 64'h7010, 1'b0);

    // R7 address computation sweep
    base_val = 64'h0000_1234_5678_0000;
    idx_val  = 64'h0000_0000_0000_0123;
    sp_e = 64'h80;
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < 2; e++)
          for (int d = 0; d < 4; d++) begin
            scale_sel = 2'(s); base_sp = b[0]; idx_en = e[0]; idx_sp = 1'b0;
            disp = dlist[d];
            bsel = b[0] ? sp_e : base_val;
            exp_ea = bsel + (e[0] ? idx_val * (64'd1 << s) : 64'd0)
                   + {{32{dlist[d][31]}}, dlist[d]};
            issue(3'd7, 64'h0, 64'h0, 64'h7100 + 64'(s), 1'b0);
            check("R7 ea", o_dwe ? o_dval : ~exp_ea, exp_ea);
          end
    check("R7 ip", ip_o, 64'h7103);

    // R8 stack pointer named as index
    idx_en = 1'b1; idx_sp = 1'b1;
    issue(3'd7, 64'h0, 64'h0, 64'hBBBB, 1'b0);
    check("R8 idx_err", {61'd0, o_ierr, o_done, o_dwe}, 64'd4);
    check("R8 ip kept", ip_o, 64'h7103);
    check("R8 sp kept", sp_o, 64'h80);
    idx_en = 1'b0; idx_sp = 1'b0;

    // R10 request held during a call that completes in the same cycle
    lat = 2;
    @(negedge clk);
    req_op = 3'd3; tgt_val = 64'h9000; nxt_ip = 64'h7200; req_valid = 1'b1;
    @(negedge clk);
    req_op = 3'd5; tgt_val = 64'hDEAD;
    for (int i = 0; i < 40; i++) begin
      if (done) break;
      check("R10 ip frozen while busy", ip_o, 64'h7103);
      @(negedge clk);
    end
    req_valid = 1'b0;
    check("R10 call wins", ip_o, 64'h9000);
    check("R10 call sp", sp_o, 64'h78);
    @(negedge clk);
    check("R10 held request ignored", {63'd0, done}, 64'd0);
    check("R10 ip stays", ip_o, 64'h9000);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule